// File: doc/BRIEF.md
# CAN Controller Interrupt Register

This block holds the interrupt state of a CAN controller in a single 32-bit memory-mapped word. Eight event sources feed it as one-cycle pulses from the surrounding controller logic: bus-off, passive warning, passive error, receive FIFO full, transmit FIFO empty, receive frame end, transmit frame end and general error. Each pulse latches a sticky raw flag. A per-source enable gates that flag into a masked flag, and the OR of the masked flags drives one interrupt line.

Software reaches the block through a plain register port. A write strobe with a 32-bit data word updates the enables and issues write-one clears in the same access. The read data reflects the current state at all times. The port has no handshake and no back-pressure: a write is taken on every clock edge where the strobe is high. The word is split into four byte lanes, and each lane lists the eight sources in the same order.

Top module: `can_irq_reg`

## Requirements
- R1: After reset every raw flag and every enable is 0, so the read data is 0x00000000 and irq_o is 0.
- R2: An event pulse on evt_i[i] sets raw flag i, read at bit 24+i, from the next clock edge on, whether or not source i is enabled. Bit i of evt_i and of each lane means, from 0 upward: bus-off, passive warning, passive error, RX FIFO full, TX FIFO empty, RX frame end, TX frame end, error.
- R3: A raw flag stays set until a clear removes it.
- R4: Bits 15:8 are the enables. A write stores reg_wdata[15:8] into them, and they read back as written.
- R5: Bits 7:0 read as the masked status, raw AND enable for each source.
- R6: A write with reg_wdata[16+i]=1 clears raw flag i at that clock edge. A 0 in that bit leaves the flag unchanged. Bits 23:16 always read as 0.
- R7: When an event pulse and a clear hit the same source in the same cycle, the event wins and the raw flag is set afterwards.
- R8: irq_o is 1 exactly when any masked status bit is 1.
- R9: Write data in bits 7:0 and 31:24 has no effect on any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 8 | One-cycle event pulses, one per source |
| reg_wr_en | input | 1 | Write strobe for the register word |
| reg_wdata | input | 32 | Write data: enables in 15:8, clears in 23:16 |
| reg_rdata | output | 32 | Current word: masked, enable, zero, raw lanes |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Two functions can land on the same source in the same clock: the arrival of an event pulse and a software write-one clear. The bench provokes this by raising evt_i for a source in the same cycle as a write that sets its clear bit. It does this both when the flag was already set and when it was clear. Another source is cleared in the same write. The bench then expects the colliding flag to read as set and the other flag to read as cleared. It also runs an enable write in the same cycle as an event on that source, and checks that the masked bit and irq_o follow on the next edge.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  localparam int unsigned SRC_N = 8;

  typedef enum logic [2:0] {
    SRC_BUS_OFF   = 3'd0,
    SRC_PASS_WARN = 3'd1,
    SRC_PASS_ERR  = 3'd2,
    SRC_RXF_FULL  = 3'd3,
    SRC_TXF_EMPTY = 3'd4,
    SRC_RX_DONE   = 3'd5,
    SRC_TX_DONE   = 3'd6,
    SRC_ERROR     = 3'd7
  } irq_src_e;

  // lane index within the word; lane k occupies bits k*SRC_N +: SRC_N
  localparam int unsigned LANE_MASKED = 0;
  localparam int unsigned LANE_ENABLE = 1;
  localparam int unsigned LANE_CLEAR  = 2;
  localparam int unsigned LANE_RAW    = 3;
  localparam int unsigned LANE_N      = 4;
endpackage

// File: rtl/can_irq_src_cell.sv
module can_irq_src_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic clr,
  input  logic en_we,
  input  logic en_d,
  output logic raw_q,
  output logic en_q,
  output logic masked
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      if (en_we) en_q <= en_d;
      // a new event outranks a clear arriving in the same cycle
      if (evt)      raw_q <= 1'b1;
      else if (clr) raw_q <= 1'b0;
    end
  end

  assign masked = raw_q & en_q;
endmodule

// File: rtl/can_irq_view.sv
module can_irq_view
  import can_irq_pkg::*;
#(
  parameter int unsigned NSRC = 8,
  localparam int unsigned WORD_W = NSRC * LANE_N
) (
  input  logic [NSRC-1:0]   raw,
  input  logic [NSRC-1:0]   en,
  input  logic [NSRC-1:0]   masked,
  output logic [WORD_W-1:0] word,
  output logic              irq
);
  always_comb begin
    word = '0;
    word[LANE_MASKED*NSRC +: NSRC] = masked;
    word[LANE_ENABLE*NSRC +: NSRC] = en;
    word[LANE_RAW*NSRC    +: NSRC] = raw;
    // the clear lane is write-only and stays zero
  end

  assign irq = |masked;
endmodule

// File: rtl/can_irq_reg.sv
module can_irq_reg
  import can_irq_pkg::*;
#(
  parameter int unsigned NSRC = SRC_N,
  localparam int unsigned WORD_W = NSRC * LANE_N,
  localparam int unsigned EN_LO  = LANE_ENABLE * NSRC,
  localparam int unsigned CLR_LO = LANE_CLEAR * NSRC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   evt_i,
  input  logic              reg_wr_en,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              irq_o
);
  logic [NSRC-1:0] raw_q;
  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] masked;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    can_irq_src_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    (evt_i[s]),
      .clr    (reg_wr_en & reg_wdata[CLR_LO+s]),
      .en_we  (reg_wr_en),
      .en_d   (reg_wdata[EN_LO+s]),
      .raw_q  (raw_q[s]),
      .en_q   (en_q[s]),
      .masked (masked[s])
    );
  end

  can_irq_view #(.NSRC(NSRC)) u_view (
    .raw    (raw_q),
    .en     (en_q),
    .masked (masked),
    .word   (reg_rdata),
    .irq    (irq_o)
  );
endmodule

// File: rtl/can_irq_reg_chk.sv
module can_irq_reg_chk #(
  parameter int unsigned NSRC = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC-1:0]   evt_i,
  input logic              reg_wr_en,
  input logic [4*NSRC-1:0] reg_wdata,
  input logic [4*NSRC-1:0] reg_rdata,
  input logic              irq_o
);
  p_clear_lane_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[3*NSRC-1:2*NSRC] == '0);

  p_masked_view_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[NSRC-1:0] == (reg_rdata[4*NSRC-1:3*NSRC] & reg_rdata[2*NSRC-1:NSRC]));

  p_irq_or_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (|reg_rdata[NSRC-1:0]));

  p_enable_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> reg_rdata[2*NSRC-1:NSRC] == $past(reg_wdata[2*NSRC-1:NSRC]));

  for (genvar s = 0; s < NSRC; s++) begin : g_p
    p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[s] |=> reg_rdata[3*NSRC+s]);

    p_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i[s] && reg_wr_en && reg_wdata[2*NSRC+s]) |=> reg_rdata[3*NSRC+s]);

    p_clear_works_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt_i[s] && reg_wr_en && reg_wdata[2*NSRC+s]) |=> !reg_rdata[3*NSRC+s]);

    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[3*NSRC+s] && !(reg_wr_en && reg_wdata[2*NSRC+s])) |=> reg_rdata[3*NSRC+s]);

    p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_rdata[3*NSRC+s] && !evt_i[s]) |=> !reg_rdata[3*NSRC+s]);
  end
endmodule

bind can_irq_reg can_irq_reg_chk #(.NSRC(NSRC)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_i     (evt_i),
  .reg_wr_en (reg_wr_en),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .irq_o     (irq_o)
);

// File: tb/can_irq_reg_tb_top.sv
module can_irq_reg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  evt_i = '0;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;

  int n_checks = 0;
  int n_errs = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_irq_reg dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt_i),
    .reg_wr_en (reg_wr_en),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_o     (irq_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // advance one edge and land 1 time unit after it
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [31:0] d);
    reg_wr_en = 1'b1;
    reg_wdata = d;
    tick();
    reg_wr_en = 1'b0;
    reg_wdata = '0;
  endtask

  task automatic pulse(logic [7:0] e);
    evt_i = e;
    tick();
    evt_i = '0;
  endtask

  function automatic logic [31:0] word(logic [7:0] raw, logic [7:0] en);
    return {raw, 8'h00, en, raw & en};
  endfunction

  task automatic t_reset();
    check("R1 rdata after reset", reg_rdata, 32'h0);
    check("R1 irq after reset", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_raw_unmasked();
    pulse(8'h01);
    check("R2 bus-off raw with enables off", reg_rdata, word(8'h01, 8'h00));
    check("R8 irq low when nothing enabled", {31'b0, irq_o}, 32'h0);
    tick(); tick();
    check("R3 raw held", reg_rdata, word(8'h01, 8'h00));
    wr(32'h0001_0000);
  endtask

  task automatic t_walk();
    for (int s = 0; s < 8; s++) begin
      pulse(8'(1 << s));
      check($sformatf("R2 walk source %0d", s), reg_rdata, word(8'(1 << s), 8'h00));
      wr(32'h00FF_0000);
    end
    check("R6 all cleared after walk", reg_rdata, 32'h0);
  endtask

  task automatic t_enable_mask();
    wr(32'h0000_A500);
    check("R4 enables read back", reg_rdata, word(8'h00, 8'hA5));
    pulse(8'h0F);
    check("R5 masked = raw & en", reg_rdata, word(8'h0F, 8'hA5));
    check("R8 irq high", {31'b0, irq_o}, 32'h1);
    wr(32'h0000_5A00);
    check("R5 mask follows new enables", reg_rdata, word(8'h0F, 8'h5A));
    wr(32'h0000_F000);
    check("R8 irq low when masked out", {31'b0, irq_o}, 32'h0);
    check("R3 raw survives enable changes", reg_rdata, word(8'h0F, 8'hF0));
  endtask

  task automatic t_clear();
    wr(32'h0002_F000);
    check("R6 clear source 1 only", reg_rdata, word(8'h0D, 8'hF0));
    wr(32'h0000_F000);
    check("R6 zero clear bits no effect", reg_rdata, word(8'h0D, 8'hF0));
    check("R6 clear lane reads zero", {24'b0, reg_rdata[23:16]}, 32'h0);
    wr(32'h00FF_F000);
    check("R6 clear all", reg_rdata, word(8'h00, 8'hF0));
  endtask

  task automatic t_collide();
    pulse(8'h40);
    evt_i = 8'hC0;
    reg_wr_en = 1'b1;
    reg_wdata = 32'h00C0_F000;
    tick();
    evt_i = '0; reg_wr_en = 1'b0; reg_wdata = '0;
    check("R7 event beats clear", reg_rdata, word(8'hC0, 8'hF0));
    evt_i = 8'h20;
    reg_wr_en = 1'b1;
    reg_wdata = 32'h0060_F000;
    tick();
    evt_i = '0; reg_wr_en = 1'b0; reg_wdata = '0;
    check("R7 event wins, neighbour cleared", reg_rdata, word(8'hA0, 8'hF0));
    wr(32'h00FF_0000);
    evt_i = 8'h08;
    reg_wr_en = 1'b1;
    reg_wdata = 32'h0000_0800;
    tick();
    evt_i = '0; reg_wr_en = 1'b0; reg_wdata = '0;
    check("R8 enable and event in same cycle", {31'b0, irq_o}, 32'h1);
    wr(32'h00FF_0000);
  endtask

  task automatic t_readonly();
    wr(32'hFF00_00FF);
    check("R9 writes to masked/raw lanes ignored", reg_rdata, 32'h0);
    check("R9 irq unaffected", {31'b0, irq_o}, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_raw_unmasked();
    t_walk();
    t_enable_mask();
    t_clear();
    t_collide();
    t_readonly();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end
endmodule